// File: doc/BRIEF.md
# Dual-Destination GPIO Interrupt Controller

A 32-pin general-purpose I/O block on a 32-bit register bus that also takes byte and halfword writes through per-lane byte enables. Each pin is an input or an output. Input pins are synchronized and watched for rising edges, falling edges, a high level and a low level. Each detected event is recorded in two independent status banks. Each bank has its own enable register and its own interrupt line, so two processors can take the same pin events and acknowledge them separately.

Software acknowledges events by writing ones to a status bank. A pin configured for level detection whose level still matches is flagged again one cycle after the acknowledge. The enable, wake-enable and data-out registers each have a set alias and a clear alias, so single bits can be changed without a read-modify-write. A sticky wakeup request can be raised by enabled pins when the configuration register allows it. A write to the configuration register with its reset bit set returns every register to its reset value.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset, the registers read as follows: revision = parameter `REVISION`, system status (0x14) = 1, output enable (0x34) = all ones, control (0x30) = 2. All other registers read 0. Both interrupt lines, the wakeup line and every pin drive enable are low.
- R2: `pin_drive_en[i]` is 1 exactly where output-enable bit i is 0. `pin_out` always equals the data-out register (0x3C).
- R3: Writing 1s to 0x94/0x90 sets/clears data-out bits, to 0x64/0x60 sets/clears bank-A enable bits (0x1C), to 0x74/0x70 sets/clears bank-B enable bits (0x2C), and to 0x84/0x80 sets/clears wake-enable bits (0x20). Reading an alias address returns the register it modifies.
- R4: Only an input pin (output-enable bit 1) raises an event. A 0-to-1 change raises one if its rising (0x48) or level-high (0x44) bit is set. A 1-to-0 change raises one if its falling (0x4C) or level-low (0x40) bit is set. A pin change applied before clock edge k appears in status after edge k+2.
- R5: An event sets its bit in both status registers (bank A 0x18, bank B 0x28). `irq_a` and `irq_b` are high whenever their bank's status AND enable is nonzero.
- R6: Writing 1s to a status address clears those bits in that bank only. A clear and a new event on the same bit at the same edge leave the bit set.
- R7: One cycle after a write to a bank's status, status bits of that bank are set again for input pins whose current level matches a level bit. The same happens for both banks one cycle after a write to output enable, level-low or level-high.
- R8: The system configuration register (0x10) stores only the bits in mask 0x1D. The control register stores only bits 2:0.
- R9: A configuration write with bit 1 set returns every register to its reset value and then stores the written value masked by 0x1D.
- R10: `wake_req` rises after an event on a pin whose wake-enable bit is set, and only while configuration bit 2 is 1 and bits 4:3 are nonzero. It then stays high until the next configuration write.
- R11: A sub-word write to an ordinary register keeps the bytes whose enable is 0. For status, set and clear addresses, those bytes count as zero.
- R12: Data in (0x38) shows the pin levels two clock edges after they change. Writes to revision, system status or data in change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output levels |
| pin_drive_en | output | 32 | 1 where the pin is driven |
| irq_a | output | 1 | Bank-A interrupt |
| irq_b | output | 1 | Bank-B interrupt |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
Register writes take effect at the edge on which the strobe is sampled, so the bench reads them back at the falling edge after that edge. Level re-assertion is due one edge later, and the bench checks both the cleared state and the re-set state one cycle apart. A pin change needs two edges to reach data in and three edges to reach status, the interrupt lines and the wakeup line. The bench changes pins just after a falling edge and counts falling edges before it samples. It also samples once a cycle early to confirm the result has not yet arrived. For the clear-versus-event test, the bench drives the acknowledge so that it lands on exactly the edge where the event is captured.

// File: rtl/gpio_dual_irq_pkg.sv
package gpio_dual_irq_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int CFG_W  = 5;
  localparam int CTRL_W = 3;
  localparam int DBT_W  = 8;

  localparam logic [CFG_W-1:0]  CFG_KEEP   = 5'h1D;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 3'd2;

  localparam logic [7:0] OFS_REV      = 8'h00;
  localparam logic [7:0] OFS_CFG      = 8'h10;
  localparam logic [7:0] OFS_SSTAT    = 8'h14;
  localparam logic [7:0] OFS_STAT_A   = 8'h18;
  localparam logic [7:0] OFS_EN_A     = 8'h1C;
  localparam logic [7:0] OFS_WAKE     = 8'h20;
  localparam logic [7:0] OFS_STAT_B   = 8'h28;
  localparam logic [7:0] OFS_EN_B     = 8'h2C;
  localparam logic [7:0] OFS_CTRL     = 8'h30;
  localparam logic [7:0] OFS_OE       = 8'h34;
  localparam logic [7:0] OFS_DIN      = 8'h38;
  localparam logic [7:0] OFS_DOUT     = 8'h3C;
  localparam logic [7:0] OFS_LVL_LO   = 8'h40;
  localparam logic [7:0] OFS_LVL_HI   = 8'h44;
  localparam logic [7:0] OFS_RISE     = 8'h48;
  localparam logic [7:0] OFS_FALL     = 8'h4C;
  localparam logic [7:0] OFS_DB_EN    = 8'h50;
  localparam logic [7:0] OFS_DB_TIME  = 8'h54;
  localparam logic [7:0] OFS_EN_A_CLR = 8'h60;
  localparam logic [7:0] OFS_EN_A_SET = 8'h64;
  localparam logic [7:0] OFS_EN_B_CLR = 8'h70;
  localparam logic [7:0] OFS_EN_B_SET = 8'h74;
  localparam logic [7:0] OFS_WK_CLR   = 8'h80;
  localparam logic [7:0] OFS_WK_SET   = 8'h84;
  localparam logic [7:0] OFS_DO_CLR   = 8'h90;
  localparam logic [7:0] OFS_DO_SET   = 8'h94;

  // Expand byte enables into a bit mask.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Ordinary register: unwritten bytes keep the current contents.
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] cur,
                                                    input logic [DATA_W-1:0] wd,
                                                    input logic [LANES-1:0]  be);
    logic [DATA_W-1:0] m;
    m = lane_mask(be);
    return (wd & m) | (cur & ~m);
  endfunction

  // Edge and level-change events on input pins.
  function automatic logic [DATA_W-1:0] pin_events(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] prev,
                                                   input logic [DATA_W-1:0] is_in,
                                                   input logic [DATA_W-1:0] rise,
                                                   input logic [DATA_W-1:0] fall,
                                                   input logic [DATA_W-1:0] lo,
                                                   input logic [DATA_W-1:0] hi);
    logic [DATA_W-1:0] up, dn;
    up = cur & ~prev;
    dn = ~cur & prev;
    return is_in & ((up & (rise | hi)) | (dn & (fall | lo)));
  endfunction

  // Input pins whose present level matches an enabled level detect.
  function automatic logic [DATA_W-1:0] level_hits(input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] is_in,
                                                   input logic [DATA_W-1:0] lo,
                                                   input logic [DATA_W-1:0] hi);
    return is_in & ((cur & hi) | (~cur & lo));
  endfunction
endpackage

// File: rtl/gpio_di_sync.sv
module gpio_di_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_di_detect.sv
module gpio_di_detect
  import gpio_dual_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] is_in,
  input  logic [DATA_W-1:0] rise_en,
  input  logic [DATA_W-1:0] fall_en,
  input  logic [DATA_W-1:0] lo_en,
  input  logic [DATA_W-1:0] hi_en,
  output logic [DATA_W-1:0] evt
);
  logic [DATA_W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  assign evt = pin_events(din, prev_q, is_in, rise_en, fall_en, lo_en, hi_en);
endmodule

// File: rtl/gpio_di_bank.sv
module gpio_di_bank
  import gpio_dual_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic [DATA_W-1:0] evt,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic              relevel,
  input  logic [DATA_W-1:0] lvl_hits,
  input  logic              en_load,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic [DATA_W-1:0] en_full,
  input  logic [DATA_W-1:0] en_lane,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] enable,
  output logic              irq
);
  logic [DATA_W-1:0] status_next;
  logic [DATA_W-1:0] enable_next;

  // A new event wins over a clear of the same bit.
  assign status_next = (status & ~clr_bits) | evt | (relevel ? lvl_hits : '0);

  always_comb begin
    enable_next = enable;
    if (en_load)     enable_next = en_full;
    else if (en_set) enable_next = enable | en_lane;
    else if (en_clr) enable_next = enable & ~en_lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else if (srst) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= status_next;
      enable <= enable_next;
    end
  end

  assign irq = |(status & enable);

  // Status bits only fall through an explicit acknowledge or soft reset.
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits == '0 && !srst) |=> ((status & $past(status)) == $past(status)));

  // Every detected event lands in this bank at the next edge.
  assert_event_recorded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!srst && evt != '0) |=> ((status & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
  import gpio_dual_irq_pkg::*;
#(
  parameter logic [31:0] REVISION    = 32'h0000_0025,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [LANES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_drive_en,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_req
);
  localparam int NBANK = 2;

  logic [CFG_W-1:0]  cfg_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DBT_W-1:0]  db_time_q;
  logic [DATA_W-1:0] wake_en_q, oe_q, dout_q, lo_q, hi_q, rise_q, fall_q, db_en_q;
  logic              wake_q;
  logic [NBANK-1:0]  relevel_q;

  logic [DATA_W-1:0] din_s, evt, lvl_hits, rd_cur, wr_merged, wr_lane;
  logic [NBANK-1:0][DATA_W-1:0] stat_v, en_v;
  logic [NBANK-1:0]  irq_v;
  logic              srst, cfg_wr, lvl_wr, wake_hit;

  // ---------------- pin path ----------------
  gpio_di_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s));

  gpio_di_detect u_detect (
    .clk(clk), .rst_n(rst_n), .din(din_s), .is_in(oe_q),
    .rise_en(rise_q), .fall_en(fall_q), .lo_en(lo_q), .hi_en(hi_q), .evt(evt));

  assign lvl_hits     = level_hits(din_s, oe_q, lo_q, hi_q);
  assign pin_out      = dout_q;
  assign pin_drive_en = ~oe_q;

  // ---------------- read mux ----------------
  always_comb begin
    rd_cur = '0;
    case (bus_addr)
      OFS_REV:                                rd_cur = REVISION;
      OFS_CFG:                                rd_cur = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
      OFS_SSTAT:                              rd_cur = {{(DATA_W-1){1'b0}}, 1'b1};
      OFS_STAT_A:                             rd_cur = stat_v[0];
      OFS_EN_A, OFS_EN_A_CLR, OFS_EN_A_SET:   rd_cur = en_v[0];
      OFS_WAKE, OFS_WK_CLR, OFS_WK_SET:       rd_cur = wake_en_q;
      OFS_STAT_B:                             rd_cur = stat_v[1];
      OFS_EN_B, OFS_EN_B_CLR, OFS_EN_B_SET:   rd_cur = en_v[1];
      OFS_CTRL:                               rd_cur = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      OFS_OE:                                 rd_cur = oe_q;
      OFS_DIN:                                rd_cur = din_s;
      OFS_DOUT, OFS_DO_CLR, OFS_DO_SET:       rd_cur = dout_q;
      OFS_LVL_LO:                             rd_cur = lo_q;
      OFS_LVL_HI:                             rd_cur = hi_q;
      OFS_RISE:                               rd_cur = rise_q;
      OFS_FALL:                               rd_cur = fall_q;
      OFS_DB_EN:                              rd_cur = db_en_q;
      OFS_DB_TIME:                            rd_cur = {{(DATA_W-DBT_W){1'b0}}, db_time_q};
      default:                                rd_cur = '0;
    endcase
  end
  assign bus_rdata = rd_cur;

  // ---------------- write decode ----------------
  assign wr_merged = merge_lanes(rd_cur, bus_wdata, bus_be);
  assign wr_lane   = bus_wdata & lane_mask(bus_be);
  assign cfg_wr    = bus_we && (bus_addr == OFS_CFG);
  assign srst      = cfg_wr && wr_merged[1];
  assign lvl_wr    = bus_we && (bus_addr == OFS_OE || bus_addr == OFS_LVL_LO ||
                                bus_addr == OFS_LVL_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0; ctrl_q <= CTRL_RESET; db_time_q <= '0;
      wake_en_q <= '0; oe_q <= '1; dout_q <= '0; lo_q <= '0; hi_q <= '0;
      rise_q <= '0; fall_q <= '0; db_en_q <= '0;
    end else if (srst) begin
      cfg_q <= wr_merged[CFG_W-1:0] & CFG_KEEP; ctrl_q <= CTRL_RESET; db_time_q <= '0;
      wake_en_q <= '0; oe_q <= '1; dout_q <= '0; lo_q <= '0; hi_q <= '0;
      rise_q <= '0; fall_q <= '0; db_en_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_CFG:     cfg_q     <= wr_merged[CFG_W-1:0] & CFG_KEEP;
        OFS_CTRL:    ctrl_q    <= wr_merged[CTRL_W-1:0];
        OFS_DB_TIME: db_time_q <= wr_merged[DBT_W-1:0];
        OFS_WAKE:    wake_en_q <= wr_merged;
        OFS_WK_CLR:  wake_en_q <= wake_en_q & ~wr_lane;
        OFS_WK_SET:  wake_en_q <= wake_en_q | wr_lane;
        OFS_OE:      oe_q      <= wr_merged;
        OFS_DOUT:    dout_q    <= wr_merged;
        OFS_DO_CLR:  dout_q    <= dout_q & ~wr_lane;
        OFS_DO_SET:  dout_q    <= dout_q | wr_lane;
        OFS_LVL_LO:  lo_q      <= wr_merged;
        OFS_LVL_HI:  hi_q      <= wr_merged;
        OFS_RISE:    rise_q    <= wr_merged;
        OFS_FALL:    fall_q    <= wr_merged;
        OFS_DB_EN:   db_en_q   <= wr_merged;
        default: ;
      endcase
    end
  end

  // ---------------- interrupt banks ----------------
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [7:0] A_STAT = (g == 0) ? OFS_STAT_A   : OFS_STAT_B;
    localparam logic [7:0] A_EN   = (g == 0) ? OFS_EN_A     : OFS_EN_B;
    localparam logic [7:0] A_ENS  = (g == 0) ? OFS_EN_A_SET : OFS_EN_B_SET;
    localparam logic [7:0] A_ENC  = (g == 0) ? OFS_EN_A_CLR : OFS_EN_B_CLR;

    logic stat_wr;
    assign stat_wr = bus_we && (bus_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    relevel_q[g] <= 1'b0;
      else if (srst) relevel_q[g] <= 1'b0;
      else           relevel_q[g] <= stat_wr || lvl_wr;
    end

    gpio_di_bank u_bank (
      .clk(clk), .rst_n(rst_n), .srst(srst), .evt(evt),
      .clr_bits(stat_wr ? wr_lane : '0),
      .relevel(relevel_q[g]), .lvl_hits(lvl_hits),
      .en_load(bus_we && bus_addr == A_EN),
      .en_set(bus_we && bus_addr == A_ENS),
      .en_clr(bus_we && bus_addr == A_ENC),
      .en_full(wr_merged), .en_lane(wr_lane),
      .status(stat_v[g]), .enable(en_v[g]), .irq(irq_v[g]));
  end

  assign irq_a = irq_v[0];
  assign irq_b = irq_v[1];

  // ---------------- wakeup ----------------
  assign wake_hit = (|(evt & wake_en_q)) && cfg_q[2] && (cfg_q[4:3] != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wake_q <= 1'b0;
    else if (cfg_wr) wake_q <= 1'b0;
    else             wake_q <= wake_q | wake_hit;
  end
  assign wake_req = wake_q;

  // Wakeup may only rise while the configuration permitted it.
  assert_wake_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(cfg_q[2] && (cfg_q[4:3] != 2'b00)));

  // Soft reset leaves direction all-input and control at its reset code.
  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (oe_q == '1 && ctrl_q == CTRL_RESET && en_v[0] == '0 && en_v[1] == '0));
endmodule

// File: tb/gpio_dual_irq_tb.sv
module gpio_dual_irq_tb;
  localparam logic [31:0] EXP_REV = 32'h0000_0025;

  localparam logic [7:0] R_REV = 8'h00, R_CFG = 8'h10, R_SST = 8'h14, R_STA = 8'h18,
    R_ENA = 8'h1C, R_WK = 8'h20, R_STB = 8'h28, R_ENB = 8'h2C, R_CTL = 8'h30,
    R_OE = 8'h34, R_DIN = 8'h38, R_DO = 8'h3C, R_LO = 8'h40, R_HI = 8'h44,
    R_RI = 8'h48, R_FA = 8'h4C, R_ENA_C = 8'h60, R_ENA_S = 8'h64,
    R_ENB_C = 8'h70, R_ENB_S = 8'h74, R_WK_C = 8'h80, R_WK_S = 8'h84,
    R_DO_C = 8'h90, R_DO_S = 8'h94;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pins = '0;
  logic [31:0] pin_out, pin_drive_en;
  logic        irq_a, irq_b, wake_req;

  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpio_dual_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_drive_en(pin_drive_en),
    .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wrb(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrb(a, d, 4'hF);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_status();
    wr(R_STA, 32'hFFFF_FFFF);
    wr(R_STB, 32'hFFFF_FFFF);
    waitn(1);
  endtask

  task automatic test_reset();
    rdchk("R1 revision", R_REV, EXP_REV);
    rdchk("R1 sysstatus", R_SST, 32'd1);
    rdchk("R1 oe", R_OE, 32'hFFFF_FFFF);
    rdchk("R1 ctrl", R_CTL, 32'd2);
    rdchk("R1 cfg", R_CFG, 32'd0);
    rdchk("R1 status A", R_STA, 32'd0);
    rdchk("R1 enable B", R_ENB, 32'd0);
    chk("R1 irq/wake", {29'd0, irq_a, irq_b, wake_req}, 32'd0);
    chk("R1 drive_en", pin_drive_en, 32'd0);
  endtask

  task automatic test_drive_alias();
    wr(R_OE, 32'hFFFF_0000);
    chk("R2 drive_en", pin_drive_en, 32'h0000_FFFF);
    wr(R_DO_S, 32'h0000_000F);
    chk("R2 pin_out after set", pin_out, 32'h0000_000F);
    wr(R_DO_C, 32'h0000_0003);
    chk("R3 dout clear alias", pin_out, 32'h0000_000C);
    rdchk("R3 read via dout alias", R_DO_C, 32'h0000_000C);
    wr(R_ENA_S, 32'h0000_00F0);
    wr(R_ENA_C, 32'h0000_0030);
    rdchk("R3 enable A set/clear", R_ENA, 32'h0000_00C0);
    rdchk("R3 enable A alias read", R_ENA_S, 32'h0000_00C0);
    wr(R_ENB_S, 32'h0000_0101);
    wr(R_ENB_C, 32'h0000_0001);
    rdchk("R3 enable B set/clear", R_ENB, 32'h0000_0100);
    wr(R_WK_S, 32'h0000_0006);
    wr(R_WK_C, 32'h0000_0002);
    rdchk("R3 wake enable set/clear", R_WK_C, 32'h0000_0004);
    wr(R_ENA, 32'd0); wr(R_ENB, 32'd0); wr(R_WK, 32'd0);
  endtask

  task automatic test_edges();
    wr(R_RI, 32'h0001_0000);
    wr(R_FA, 32'h0002_0000);
    wr(R_ENA, 32'h0003_0000);
    pins[17] = 1'b1;
    waitn(4);
    rdchk("R4 rise on fall-only pin ignored", R_STA, 32'd0);
    pins[16] = 1'b1;
    waitn(2);
    rdchk("R4 not yet after two edges", R_STA, 32'd0);
    waitn(1);
    rdchk("R4 rising event status A", R_STA, 32'h0001_0000);
    rdchk("R5 rising event status B", R_STB, 32'h0001_0000);
    chk("R5 irq_a high, irq_b low", {30'd0, irq_a, irq_b}, 32'd2);
    wr(R_ENB, 32'h0001_0000);
    chk("R5 irq_b after enable", {31'd0, irq_b}, 32'd1);
    pins[17] = 1'b0;
    waitn(3);
    rdchk("R4 falling event", R_STA, 32'h0003_0000);
    wr(R_STA, 32'h0003_0000);
    rdchk("R6 clear bank A", R_STA, 32'd0);
    rdchk("R6 bank B untouched", R_STB, 32'h0003_0000);
    chk("R5 irq_a low after clear", {31'd0, irq_a}, 32'd0);
    wr(R_STB, 32'h0003_0000);
    chk("R5 irq_b low after clear", {31'd0, irq_b}, 32'd0);
    wr(R_RI, 32'h0001_0001);
    pins[0] = 1'b1;
    waitn(4);
    rdchk("R4 output pin raises nothing", R_STA, 32'd0);
    wr(R_ENA, 32'd0); wr(R_ENB, 32'd0);
  endtask

  task automatic test_level();
    pins[20] = 1'b1;
    waitn(4);
    rdchk("R7 no event without detect", R_STA, 32'd0);
    wr(R_HI, 32'h0010_0000);
    rdchk("R7 not yet at write edge", R_STA, 32'd0);
    waitn(1);
    rdchk("R7 level-high write re-asserts A", R_STA, 32'h0010_0000);
    rdchk("R7 level-high write re-asserts B", R_STB, 32'h0010_0000);
    wr(R_STA, 32'h0010_0000);
    rdchk("R7 cleared at write edge", R_STA, 32'd0);
    waitn(1);
    rdchk("R7 re-asserted after clear", R_STA, 32'h0010_0000);
    wr(R_HI, 32'd0);
    wr(R_LO, 32'h0020_0000);
    waitn(1);
    rdchk("R7 level-low match", R_STA, 32'h0030_0000);
    wr(R_LO, 32'd0);
    clear_status();
    rdchk("R7 stays clear without level bits", R_STA, 32'd0);
  endtask

  task automatic test_priority();
    wr(R_RI, 32'h0400_0000);
    pins[26] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = R_STA; bus_wdata = 32'h0400_0000; bus_be = 4'hF;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
    rdchk("R6 event wins over clear", R_STA, 32'h0400_0000);
    clear_status();
  endtask

  task automatic test_cfg();
    wr(R_CFG, 32'h0000_00FD);
    rdchk("R8 cfg mask", R_CFG, 32'h0000_001D);
    wr(R_CTL, 32'hFFFF_FFFF);
    rdchk("R8 ctrl width", R_CTL, 32'h0000_0007);
    wr(R_ENA, 32'h0000_0005);
    wr(R_OE, 32'd0);
    wr(R_DO, 32'h0000_00FF);
    wr(R_CFG, 32'h0000_0006);
    rdchk("R9 cfg after soft reset", R_CFG, 32'h0000_0004);
    rdchk("R9 oe after soft reset", R_OE, 32'hFFFF_FFFF);
    rdchk("R9 enable after soft reset", R_ENA, 32'd0);
    rdchk("R9 ctrl after soft reset", R_CTL, 32'd2);
    rdchk("R9 rise after soft reset", R_RI, 32'd0);
    chk("R9 dout after soft reset", pin_out, 32'd0);
  endtask

  task automatic test_wake();
    wr(R_WK_S, 32'h0040_0000);
    wr(R_RI, 32'h00C0_0000);
    pins[22] = 1'b0; pins[23] = 1'b0;
    waitn(4);
    pins[22] = 1'b1;
    waitn(3);
    chk("R10 no wake with idle bits zero", {31'd0, wake_req}, 32'd0);
    wr(R_CFG, 32'h0000_000C);
    pins[22] = 1'b0;
    waitn(3);
    pins[23] = 1'b1;
    waitn(3);
    chk("R10 no wake from non-enabled pin", {31'd0, wake_req}, 32'd0);
    pins[22] = 1'b1;
    waitn(2);
    chk("R10 wake not yet", {31'd0, wake_req}, 32'd0);
    waitn(1);
    chk("R10 wake asserted", {31'd0, wake_req}, 32'd1);
    waitn(5);
    chk("R10 wake sticky", {31'd0, wake_req}, 32'd1);
    wr(R_CFG, 32'h0000_000C);
    chk("R10 wake cleared by cfg write", {31'd0, wake_req}, 32'd0);
    wr(R_CFG, 32'd0);
    wr(R_RI, 32'd0);
    clear_status();
  endtask

  task automatic test_subword();
    wr(R_ENA, 32'h1122_3344);
    wrb(R_ENA, 32'hAAAA_AAAA, 4'b0010);
    rdchk("R11 byte merge", R_ENA, 32'h1122_AA44);
    wrb(R_ENA, 32'h5555_0000, 4'b1100);
    rdchk("R11 halfword merge", R_ENA, 32'h5555_AA44);
    wrb(R_ENA_S, 32'hFFFF_FFFF, 4'b0001);
    rdchk("R11 set alias lanes", R_ENA, 32'h5555_AAFF);
    wrb(R_ENA_C, 32'hFFFF_FFFF, 4'b1000);
    rdchk("R11 clear alias lanes", R_ENA, 32'h0055_AAFF);
    wr(R_RI, 32'h0300_0000);
    pins[24] = 1'b1; pins[25] = 1'b1;
    waitn(3);
    rdchk("R11 status before", R_STA, 32'h0300_0000);
    wrb(R_STA, 32'hFFFF_FFFF, 4'b0001);
    rdchk("R11 status unwritten lanes zero", R_STA, 32'h0300_0000);
    wrb(R_STA, 32'h0100_0000, 4'b1000);
    rdchk("R11 status byte clear", R_STA, 32'h0200_0000);
    wr(R_ENA, 32'd0);
    clear_status();
  endtask

  task automatic test_readonly();
    rdchk("R12 data in", R_DIN, pins);
    wr(R_DIN, 32'h0000_0000);
    wr(R_REV, 32'h0000_0000);
    wr(R_SST, 32'h0000_0000);
    rdchk("R12 revision unchanged", R_REV, EXP_REV);
    rdchk("R12 sysstatus unchanged", R_SST, 32'd1);
    rdchk("R12 data in unchanged", R_DIN, pins);
    pins[30] = 1'b1;
    waitn(1);
    rdchk("R12 data in one edge", R_DIN, pins & ~32'h4000_0000);
    waitn(1);
    rdchk("R12 data in two edges", R_DIN, pins);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    test_reset();
    test_drive_alias();
    test_edges();
    test_level();
    test_priority();
    test_cfg();
    test_wake();
    test_subword();
    test_readonly();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule